// File: doc/BRIEF.md
# Exception vector and cause unit

This unit sits beside a processor's privileged register file and decides what happens when an exception is taken. A one-cycle strobe presents the exception kind, the faulting PC, a branch-delay-slot flag and the current Status, Cause, EBase and Debug register values. One cycle later the unit returns the redirected PC together with the new register values and write enables for EPC, ErrorEPC and DEPC. It also gives a flag that requests debug mode. The register file applies these results. Returning from an exception is handled elsewhere.

Three families of exception are handled. General exceptions, which include interrupts, TLB faults and cache errors, vector off a base that depends on Status.BEV, and they record EPC only when Status.EXL is clear. Error-level entries (NMI and soft reset) save ErrorEPC and jump to the boot vector. Debug entries save DEPC and jump to the debug vector. An exception kind that matches no defined entry produces an error pulse and no update.

Kind encoding on `kind_i`: values 0 to 31 are general exceptions whose ExcCode equals the value. The remaining kinds are 32 NMI, 33 soft reset, 34 debug single step, 35 debug interrupt, 36 debug instruction break, 37 debug breakpoint, 38 debug data-break store and 39 debug data-break load. All other values are undefined.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, valid_o, err_o, dm_set_o and all three write enables are 0.
- R2: A result appears on the outputs exactly one clock edge after take_i is sampled high, and valid_o and err_o fall at the next edge if take_i is low.
- R3: General exceptions vector to base plus offset. The base is 0xBFC00200 when Status[22] (BEV) is 1, and otherwise EBase with bits 9:0 cleared. The default offset is 0x180.
- R4: An interrupt (kind 0, outside debug mode) uses offset 0x200 when Cause[23] (IV) is 1, and otherwise 0x180.
- R5: A TLB load or store (kind 2 or 3) with refill_i high uses offset 0x000 when Status[1] (EXL) is 0, and offset 0x180 when EXL is 1.
- R6: A cache error (kind 30) uses offset 0x100 when BEV is 1 and 0x20000100 when BEV is 0.
- R7: For general exceptions with EXL 0, the unit writes EPC (PC-4 with Cause[31] (BD) set in a delay slot, otherwise PC with BD cleared) and sets EXL. With EXL 1 there is no EPC write and BD is unchanged.
- R8: General exceptions write the kind into Cause[6:2] (ExcCode) and keep all other Cause bits. For coprocessor unusable (kind 11), cop_i is also written into Cause[29:28].
- R9: NMI (kind 32) sets Status[19] and soft reset (kind 33) sets Status[20]. Both also set Status[2] (ERL) and BEV, write ErrorEPC (PC-4 in a delay slot, otherwise PC), clear BD if EXL is 0, and jump to 0xBFC00000.
- R10: Debug kinds 34 to 39 set Debug bit 0, 5, 4, 1, 3 or 2 respectively, write DEPC, assert dm_set_o, clear BD if EXL is 0, leave Status unchanged and jump to 0xBFC00480. DEPC is PC-4 in a delay slot, except for single step (kind 34), which always saves PC.
- R11: Kind 0 with dm_i high is handled as a debug interrupt (kind 35).
- R12: Kinds 14, 16, 17, 19 to 21, 26 to 29, 31 and 40 to 63 raise err_o and leave valid_o, dm_set_o and all write enables at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | One-cycle strobe: take the exception |
| kind_i | input | 6 | Exception kind (encoding above) |
| refill_i | input | 1 | TLB fault was a missing entry |
| cop_i | input | 2 | Coprocessor number for coprocessor unusable |
| dm_i | input | 1 | Core is currently in debug mode |
| in_delay_i | input | 1 | Faulting instruction is in a branch delay slot |
| pc_i | input | 32 | PC of the faulting instruction |
| status_i | input | 32 | Current Status |
| cause_i | input | 32 | Current Cause |
| ebase_i | input | 32 | Current EBase |
| debug_i | input | 32 | Current Debug |
| valid_o | output | 1 | Redirect and updates are valid |
| err_o | output | 1 | Undefined kind was presented |
| next_pc_o | output | 32 | Vector address |
| epc_we_o | output | 1 | Write EPC |
| epc_o | output | 32 | New EPC |
| eepc_we_o | output | 1 | Write ErrorEPC |
| eepc_o | output | 32 | New ErrorEPC |
| depc_we_o | output | 1 | Write DEPC |
| depc_o | output | 32 | New DEPC |
| status_o | output | 32 | New Status |
| cause_o | output | 32 | New Cause |
| debug_o | output | 32 | New Debug |
| dm_set_o | output | 1 | Enter debug mode |

## Verification
The hardest cases to reach are the ones where several controls interact. One is a refill fault that arrives while EXL is already set: it must fall back to offset 0x180 and also skip the EPC write. Another is an interrupt raised in debug mode, which must turn into a debug entry. The bench sweeps every one of the 64 kind values against every combination of BEV, EXL, IV, delay slot, debug mode and refill. This covers these cases, as well as every undefined kind, against an arithmetic model.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter logic [31:0] BOOT_GEN_BASE = 32'hBFC0_0200,
  parameter logic [31:0] BOOT_VEC      = 32'hBFC0_0000,
  parameter logic [31:0] DEBUG_VEC     = 32'hBFC0_0480
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take_i,
  input  logic [5:0]  kind_i,
  input  logic        refill_i,
  input  logic [1:0]  cop_i,
  input  logic        dm_i,
  input  logic        in_delay_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] status_i,
  input  logic [31:0] cause_i,
  input  logic [31:0] ebase_i,
  input  logic [31:0] debug_i,
  output logic        valid_o,
  output logic        err_o,
  output logic [31:0] next_pc_o,
  output logic        epc_we_o,
  output logic [31:0] epc_o,
  output logic        eepc_we_o,
  output logic [31:0] eepc_o,
  output logic        depc_we_o,
  output logic [31:0] depc_o,
  output logic [31:0] status_o,
  output logic [31:0] cause_o,
  output logic [31:0] debug_o,
  output logic        dm_set_o
);
  localparam int ST_EXL = 1, ST_ERL = 2, ST_NMI = 19, ST_SR = 20, ST_BEV = 22;
  localparam int CA_BD = 31, CA_IV = 23;

  function automatic logic code_ok(input logic [4:0] c);
    case (c)
      5'd14, 5'd16, 5'd17, 5'd19, 5'd20, 5'd21,
      5'd26, 5'd27, 5'd28, 5'd29, 5'd31: code_ok = 1'b0;
      default: code_ok = 1'b1;
    endcase
  endfunction

  logic [5:0]  kind;
  logic        exl, bev, is_gen, is_rst, is_dbg;
  logic [31:0] base, offset, ret_pc;

  assign kind   = (kind_i == 6'd0 && dm_i) ? 6'd35 : kind_i;
  assign exl    = status_i[ST_EXL];
  assign bev    = status_i[ST_BEV];
  assign is_gen = !kind[5] && code_ok(kind[4:0]);
  assign is_rst = kind == 6'd32 || kind == 6'd33;
  assign is_dbg = kind >= 6'd34 && kind <= 6'd39;
  assign base   = bev ? BOOT_GEN_BASE : (ebase_i & ~32'h3FF);
  assign ret_pc = in_delay_i ? pc_i - 32'd4 : pc_i;

  always_comb begin
    case (kind)
      6'd0:       offset = cause_i[CA_IV] ? 32'h200 : 32'h180;
      6'd2, 6'd3: offset = (refill_i && !exl) ? 32'h0 : 32'h180;
      6'd30:      offset = bev ? 32'h100 : 32'h2000_0100;
      default:    offset = 32'h180;
    endcase
  end

  logic [31:0] n_pc, n_status, n_cause, n_debug;
  always_comb begin
    n_pc     = base + offset;
    n_status = status_i;
    n_cause  = cause_i;
    n_debug  = debug_i;
    if (is_gen) begin
      if (!exl) n_cause[CA_BD] = in_delay_i;
      n_cause[6:2] = kind[4:0];
      if (kind == 6'd11) n_cause[29:28] = cop_i;
      n_status[ST_EXL] = 1'b1;
    end else if (is_rst) begin
      n_pc = BOOT_VEC;
      n_status[ST_ERL] = 1'b1;
      n_status[ST_BEV] = 1'b1;
      if (kind == 6'd32) n_status[ST_NMI] = 1'b1;
      else               n_status[ST_SR]  = 1'b1;
      if (!exl) n_cause[CA_BD] = 1'b0;
    end else if (is_dbg) begin
      n_pc = DEBUG_VEC;
      if (!exl) n_cause[CA_BD] = 1'b0;
      case (kind)
        6'd34:   n_debug[0] = 1'b1;
        6'd35:   n_debug[5] = 1'b1;
        6'd36:   n_debug[4] = 1'b1;
        6'd37:   n_debug[1] = 1'b1;
        6'd38:   n_debug[3] = 1'b1;
        default: n_debug[2] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0; err_o <= 1'b0; dm_set_o <= 1'b0;
      epc_we_o <= 1'b0; eepc_we_o <= 1'b0; depc_we_o <= 1'b0;
      next_pc_o <= '0; epc_o <= '0; eepc_o <= '0; depc_o <= '0;
      status_o <= '0; cause_o <= '0; debug_o <= '0;
    end else begin
      valid_o   <= take_i && (is_gen || is_rst || is_dbg);
      err_o     <= take_i && !(is_gen || is_rst || is_dbg);
      epc_we_o  <= take_i && is_gen && !exl;
      eepc_we_o <= take_i && is_rst;
      depc_we_o <= take_i && is_dbg;
      dm_set_o  <= take_i && is_dbg;
      if (take_i) begin
        next_pc_o <= n_pc;
        epc_o     <= ret_pc;
        eepc_o    <= ret_pc;
        depc_o    <= (kind == 6'd34) ? pc_i : ret_pc;
        status_o  <= n_status;
        cause_o   <= n_cause;
        debug_o   <= n_debug;
      end
    end
  end

  AST_ONE_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({epc_we_o, eepc_we_o, depc_we_o})); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o && !dm_set_o && !epc_we_o && !eepc_we_o && !depc_we_o); // R12
  AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o || err_o) |-> $past(take_i)); // R2
  AST_EPC_EXL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we_o |-> !$past(status_i[ST_EXL]) && status_o[ST_EXL]); // R7
  AST_DEBUG_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    depc_we_o |-> next_pc_o == DEBUG_VEC && dm_set_o); // R10
  AST_BOOT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    eepc_we_o |-> next_pc_o == BOOT_VEC && status_o[ST_ERL] && status_o[ST_BEV]); // R9
endmodule

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, take = 1'b0, refill = 1'b0, dm = 1'b0, dly = 1'b0;
  logic [5:0]  kind = '0;
  logic [1:0]  cop = 2'b10;
  logic [31:0] pc = 32'h0040_1230, st = '0, ca = '0, eb = 32'h8000_1ABC, dbg = 32'h4000_0000;
  logic        valid, err, epc_we, eepc_we, depc_we, dm_set;
  logic [31:0] npc, epc, eepc, depc, st_o, ca_o, dbg_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take), .kind_i(kind), .refill_i(refill),
    .cop_i(cop), .dm_i(dm), .in_delay_i(dly), .pc_i(pc), .status_i(st),
    .cause_i(ca), .ebase_i(eb), .debug_i(dbg), .valid_o(valid), .err_o(err),
    .next_pc_o(npc), .epc_we_o(epc_we), .epc_o(epc), .eepc_we_o(eepc_we),
    .eepc_o(eepc), .depc_we_o(depc_we), .depc_o(depc), .status_o(st_o),
    .cause_o(ca_o), .debug_o(dbg_o), .dm_set_o(dm_set));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s kind=%0d st=%h act=%h exp=%h", tag, kind, st, act, exp);
    end
  endtask

  task automatic run_one(int k, int cfg);
    logic bev, exl, iv, gen, rst, dbgk, ok;
    int ek;
    logic [31:0] base, off, rpc, e_pc, e_st, e_ca, e_dbg;
    string pctag;
    kind = 6'(k); bev = cfg[0]; exl = cfg[1]; iv = cfg[2];
    dly = cfg[3]; dm = cfg[4]; refill = cfg[5];
    st = 32'h0000_F0F0 | (32'(bev) << 22) | (32'(exl) << 1);
    ca = 32'h9000_0300 | (32'(iv) << 23);
    ek = (k == 0 && dm) ? 35 : k;
    ok = !(ek inside {14, 16, 17, 19, 20, 21, 26, 27, 28, 29, 31});
    gen = ek < 32 && ok; rst = ek == 32 || ek == 33; dbgk = ek >= 34 && ek <= 39;
    rpc = dly ? pc - 4 : pc;
    base = bev ? 32'hBFC0_0200 : 32'h8000_1800;
    off = 32'h180; pctag = "R3";
    if (ek == 0) begin off = iv ? 32'h200 : 32'h180; pctag = "R4"; end
    if ((ek == 2 || ek == 3) && refill) begin off = exl ? 32'h180 : 32'h0; pctag = "R5"; end
    if (ek == 30) begin off = bev ? 32'h100 : 32'h2000_0100; pctag = "R6"; end
    e_pc = base + off; e_st = st; e_ca = ca; e_dbg = dbg;
    if (gen) begin
      e_st = st | 32'h2;
      if (!exl) e_ca[31] = dly;
      e_ca[6:2] = 5'(ek);
      if (ek == 11) e_ca[29:28] = cop;
    end else if (rst) begin
      e_pc = 32'hBFC0_0000; pctag = "R9";
      e_st = st | 32'h0040_0004 | (ek == 32 ? 32'h0008_0000 : 32'h0010_0000);
      if (!exl) e_ca[31] = 1'b0;
    end else if (dbgk) begin
      e_pc = 32'hBFC0_0480; pctag = (k == 0) ? "R11" : "R10";
      if (!exl) e_ca[31] = 1'b0;
      case (ek)
        34: e_dbg[0] = 1'b1; 35: e_dbg[5] = 1'b1; 36: e_dbg[4] = 1'b1;
        37: e_dbg[1] = 1'b1; 38: e_dbg[3] = 1'b1; default: e_dbg[2] = 1'b1;
      endcase
    end
    take = 1'b1;
    @(posedge clk); @(negedge clk);
    take = 1'b0;
    if (!(gen || rst || dbgk)) begin
      chk("R12 err", 32'(err), 32'd1);
      chk("R12 quiet", {27'd0, valid, dm_set, epc_we, eepc_we, depc_we}, 32'd0);
    end else begin
      chk("R2 valid", {30'd0, valid, err}, 32'd2);
      chk(pctag, npc, e_pc);
      chk(gen ? "R7 epc_we" : "R9 eepc_we", {29'd0, epc_we, eepc_we, depc_we},
          gen ? (exl ? 32'd0 : 32'd4) : rst ? 32'd2 : 32'd1);
      if (gen && !exl) chk("R7 epc", epc, rpc);
      if (rst) chk("R9 eepc", eepc, rpc);
      if (dbgk) chk("R10 depc", depc, ek == 34 ? pc : rpc);
      chk(gen ? "R7 status" : rst ? "R9 status" : "R10 status", st_o, e_st);
      chk(gen ? "R8 cause" : rst ? "R9 cause" : "R10 cause", ca_o, e_ca);
      if (dbgk) chk(k == 0 ? "R11 debug" : "R10 debug", dbg_o, e_dbg);
      chk("R10 dm_set", 32'(dm_set), 32'(dbgk));
    end
    @(posedge clk); @(negedge clk);
    chk("R2 pulse", {30'd0, valid, err}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", {26'd0, valid, err, dm_set, epc_we, eepc_we, depc_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 64; k++)
      for (int c = 0; c < 64; c++)
        run_one(k, c);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule